// File: doc/BRIEF.md
# Ethernet PHY Management Master

This block drives the two-wire management interface of an Ethernet PHY. Host logic programs three registers. The first is a divider value that sets the management clock rate. The second is a transmit-data word. The third is a control word that holds the PHY register address, a write-select bit and a start bit. Setting start launches exactly one 64-bit management frame. The frame either writes the transmit-data word into the addressed PHY register or reads that register into the receive-data output. The start bit reads back as 1 for the whole frame and drops by itself when the frame ends, so host logic can poll it as a busy flag.

The management clock only runs during a frame and stays low otherwise. The frame shifts out MSB first: 32 preamble ones, start pattern 01, an opcode, a fixed PHY address given as a parameter, the 5-bit register address, a turnaround pair and 16 data bits. Output data changes on falling clock edges. Returned data is sampled on rising edges. During a read the MDIO pin is released partway through the turnaround so that the PHY can drive it.

Top module: `mdio_master`

## Requirements
- R1: After reset, ctrlRdata is 0, rxData is 0, mdc is 0, mdioOe is 0 and mdioOut is 1.
- R2: Control word layout: bit 0 is start/busy, bit 1 selects write (1) or read (0), bit 2 is a spare bit that is stored and read back, and bits [7:3] hold the PHY register address. A control write made while idle stores bits [7:1], and ctrlRdata returns them in the next cycle.
- R3: A control write with bit 0 set while idle makes ctrlRdata[0] read 1 from the next cycle. The bit stays 1 for exactly 128×(N+1) system cycles and then clears by itself.
- R4: While a frame runs, mdc has a period of 2×(N+1) system cycles, where N is the divider value held when the frame started. Exactly 64 rising mdc edges occur per frame. Divider writes during a frame do not change that frame. mdc is low whenever the block is idle.
- R5: A write frame carries, in transmit order, 32 ones, 01, opcode 01, the PHY address parameter, the register address, turnaround 10 and the transmit-data word MSB first. mdioOe is 1 for all 64 bits.
- R6: A read frame carries 32 ones, 01, opcode 10, the PHY address, the register address and a driven 1 as the first turnaround bit. mdioOe is 1 for bits 0 to 46 and 0 for bits 47 to 63.
- R7: On a read, the mdioIn values sampled at the rising mdc edges of bits 48 to 63 appear in rxData, MSB first, when busy clears. A write leaves rxData unchanged.
- R8: While a frame runs, mdioOut changes only in the cycle in which mdc falls.
- R9: A control write made while busy is ignored. The stored fields keep their values and no extra frame follows.
- R10: Every register address from 0 to 31 is reachable by both reads and writes.
- R11: mdioOe is 0 whenever the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctrlWe | input | 1 | Control word write strobe |
| ctrlWdata | input | 8 | Control word write value |
| ctrlRdata | output | 8 | Control word readback, bit 0 is busy |
| divWe | input | 1 | Divider register write strobe |
| divWdata | input | 8 | Divider value N |
| txWe | input | 1 | Transmit-data register write strobe |
| txWdata | input | 16 | Transmit-data value |
| rxData | output | 16 | Receive-data register |
| mdc | output | 1 | Management clock to PHY |
| mdioOut | output | 1 | Management data driven toward the PHY |
| mdioOe | output | 1 | Output enable for mdioOut |
| mdioIn | input | 1 | Management data from the PHY |

## Verification
All 32 register addresses are swept with writes and with reads, and the divider cycles through 0, 1 and 2. Address or data bits placed in the wrong slot or order show up as frame mismatches. An off-by-one in the divider changes both the rise-to-rise interval and the total busy time. A read model drives a distinct 16-bit pattern for each address, so a shifted or reversed sample in rxData is visible. Separate runs write the control word during a frame, store fields without a start, and change the divider mid-frame. These runs separate correct ignore and latch behaviour from a design that restarts or retimes a frame.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_BITS    = 64;
  localparam int PREAMBLE_BITS = 32;
  localparam int DATA_BITS     = 16;
  localparam int ADDR_W        = 5;
  localparam int CTRL_W        = 8;
  localparam int BIT_W         = $clog2(FRAME_BITS);
  // index of the second turnaround bit and of the first data bit
  localparam int TA2_IDX       = FRAME_BITS - DATA_BITS - 1;
  localparam int DATA_IDX      = FRAME_BITS - DATA_BITS;

  typedef struct packed {
    logic load;      // capture a new frame
    logic shiftOut;  // advance to next outgoing bit (on mdc fall)
    logic sampleIn;  // capture mdioIn (on mdc rise, read data phase)
    logic finish;    // last falling edge of frame
  } mdioStrobes_t;
endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             run,
  input  logic [DIV_W-1:0] divN,
  output logic             mdc,
  output logic             riseTick,
  output logic             fallTick
);
  logic [DIV_W-1:0] cntQ;
  logic             mdcQ;
  logic             wrapHit;

  assign wrapHit  = run && (cntQ == divN);
  assign riseTick = wrapHit && !mdcQ;
  assign fallTick = wrapHit && mdcQ;
  assign mdc      = mdcQ;

  always_ff @(posedge clk) begin
    if (!rstN || !run) begin
      cntQ <= '0;
      mdcQ <= 1'b0;
    end else if (wrapHit) begin
      cntQ <= '0;
      mdcQ <= ~mdcQ;
    end else begin
      cntQ <= cntQ + 1'b1;
    end
  end
endmodule

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
  import mdio_pkg::*;
#(
  parameter int             DIV_W     = 8,
  parameter logic [DIV_W-1:0] DIV_RESET = 8'd24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWe,
  input  logic [CTRL_W-1:0] ctrlWdata,
  input  logic              divWe,
  input  logic [DIV_W-1:0]  divWdata,
  input  logic              riseTick,
  input  logic              fallTick,
  output logic              busy,
  output logic [DIV_W-1:0]  activeDiv,
  output mdioStrobes_t      strobes,
  output logic              mdioOe,
  output logic [CTRL_W-1:0] ctrlRdata
);
  typedef enum logic {ST_IDLE, ST_FRAME} ctrlState_t;

  ctrlState_t        stateQ;
  logic [CTRL_W-1:1] fieldsQ;
  logic [DIV_W-1:0]  divRegQ;
  logic [DIV_W-1:0]  activeDivQ;
  logic [BIT_W-1:0]  bitCntQ;
  logic              lastBit;
  logic              writeSel;

  assign busy      = (stateQ == ST_FRAME);
  assign writeSel  = fieldsQ[1];
  assign lastBit   = (bitCntQ == BIT_W'(FRAME_BITS - 1));
  assign activeDiv = activeDivQ;
  assign ctrlRdata = {fieldsQ, busy};

  always_comb begin
    strobes          = '0;
    strobes.load     = ctrlWe && !busy && ctrlWdata[0];
    strobes.shiftOut = fallTick && !lastBit;
    strobes.finish   = fallTick && lastBit;
    strobes.sampleIn = riseTick && !writeSel && (bitCntQ >= BIT_W'(DATA_IDX));
  end

  // drive during the whole write; release from second turnaround on reads
  assign mdioOe = busy && (writeSel || (bitCntQ < BIT_W'(TA2_IDX)));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ     <= ST_IDLE;
      fieldsQ    <= '0;
      divRegQ    <= DIV_RESET;
      activeDivQ <= DIV_RESET;
      bitCntQ    <= '0;
    end else begin
      if (divWe) divRegQ <= divWdata;
      if (ctrlWe && !busy) fieldsQ <= ctrlWdata[CTRL_W-1:1];
      unique case (stateQ)
        ST_IDLE: begin
          if (strobes.load) begin
            stateQ     <= ST_FRAME;
            activeDivQ <= divRegQ;
            bitCntQ    <= '0;
          end
        end
        ST_FRAME: begin
          if (strobes.finish) begin
            stateQ  <= ST_IDLE;
            bitCntQ <= '0;
          end else if (strobes.shiftOut) begin
            bitCntQ <= bitCntQ + 1'b1;
          end
        end
        default: stateQ <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mdio_datapath.sv
module mdio_datapath
  import mdio_pkg::*;
#(
  parameter logic [ADDR_W-1:0] PHY_ADDR = 5'd1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  mdioStrobes_t         strobes,
  input  logic                 loadWrite,
  input  logic [ADDR_W-1:0]    loadRegAddr,
  input  logic                 txWe,
  input  logic [DATA_BITS-1:0] txWdata,
  input  logic                 mdioIn,
  output logic                 mdioOut,
  output logic [DATA_BITS-1:0] rxData
);
  logic [FRAME_BITS-1:0] frameQ;
  logic [DATA_BITS-1:0]  txQ;
  logic [DATA_BITS-1:0]  rxShiftQ;
  logic [DATA_BITS-1:0]  rxQ;
  logic                  readQ;
  logic [FRAME_BITS-1:0] frameNext;

  always_comb begin
    frameNext = {
      {PREAMBLE_BITS{1'b1}},
      2'b01,
      (loadWrite ? 2'b01 : 2'b10),
      PHY_ADDR,
      loadRegAddr,
      (loadWrite ? 2'b10 : 2'b11),
      (loadWrite ? txQ : {DATA_BITS{1'b1}})
    };
  end

  assign mdioOut = frameQ[FRAME_BITS-1];
  assign rxData  = rxQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      frameQ   <= '1;
      txQ      <= '0;
      rxShiftQ <= '0;
      rxQ      <= '0;
      readQ    <= 1'b0;
    end else begin
      if (txWe) txQ <= txWdata;
      if (strobes.load) begin
        frameQ <= frameNext;
        readQ  <= !loadWrite;
      end else if (strobes.finish) begin
        frameQ <= '1;
        if (readQ) rxQ <= rxShiftQ;
      end else if (strobes.shiftOut) begin
        frameQ <= {frameQ[FRAME_BITS-2:0], 1'b1};
      end
      if (strobes.sampleIn) rxShiftQ <= {rxShiftQ[DATA_BITS-2:0], mdioIn};
    end
  end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int                DIV_W     = 8,
  parameter logic [DIV_W-1:0]  DIV_RESET = 8'd24,
  parameter logic [ADDR_W-1:0] PHY_ADDR  = 5'd1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 ctrlWe,
  input  logic [CTRL_W-1:0]    ctrlWdata,
  output logic [CTRL_W-1:0]    ctrlRdata,
  input  logic                 divWe,
  input  logic [DIV_W-1:0]     divWdata,
  input  logic                 txWe,
  input  logic [DATA_BITS-1:0] txWdata,
  output logic [DATA_BITS-1:0] rxData,
  output logic                 mdc,
  output logic                 mdioOut,
  output logic                 mdioOe,
  input  logic                 mdioIn
);
  logic             busy;
  logic [DIV_W-1:0] activeDiv;
  logic             riseTick;
  logic             fallTick;
  mdioStrobes_t     strobes;

  mdio_clkdiv #(.DIV_W(DIV_W)) u_clkdiv (
    .clk(clk), .rstN(rstN), .run(busy), .divN(activeDiv),
    .mdc(mdc), .riseTick(riseTick), .fallTick(fallTick)
  );

  mdio_ctrl #(.DIV_W(DIV_W), .DIV_RESET(DIV_RESET)) u_ctrl (
    .clk(clk), .rstN(rstN), .ctrlWe(ctrlWe), .ctrlWdata(ctrlWdata),
    .divWe(divWe), .divWdata(divWdata), .riseTick(riseTick),
    .fallTick(fallTick), .busy(busy), .activeDiv(activeDiv),
    .strobes(strobes), .mdioOe(mdioOe), .ctrlRdata(ctrlRdata)
  );

  mdio_datapath #(.PHY_ADDR(PHY_ADDR)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .loadWrite(ctrlWdata[1]), .loadRegAddr(ctrlWdata[CTRL_W-1:3]),
    .txWe(txWe), .txWdata(txWdata), .mdioIn(mdioIn),
    .mdioOut(mdioOut), .rxData(rxData)
  );
endmodule

// File: rtl/mdio_master_checker.sv
module mdio_master_checker (
  input logic       clk,
  input logic       rstN,
  input logic       ctrlWe,
  input logic [7:0] ctrlWdata,
  input logic [7:0] ctrlRdata,
  input logic       mdc,
  input logic       mdioOut,
  input logic       mdioOe
);
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlRdata[0] |-> !mdioOe); // R11
  AST_IDLE_MDC_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlRdata[0] |-> !mdc); // R4
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWe && ctrlWdata[0] && !ctrlRdata[0]) |=> ctrlRdata[0]); // R3
  AST_CTRL_STORE: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWe && !ctrlRdata[0]) |=> (ctrlRdata[7:1] == $past(ctrlWdata[7:1]))); // R2
  AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWe && ctrlRdata[0]) |=> $stable(ctrlRdata[7:1])); // R9
  AST_MDIO_ON_FALL: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlRdata[0] && $past(ctrlRdata[0]) && !$stable(mdioOut)) |-> $fell(mdc)); // R8
endmodule

bind mdio_master mdio_master_checker u_chk (
  .clk(clk), .rstN(rstN), .ctrlWe(ctrlWe), .ctrlWdata(ctrlWdata),
  .ctrlRdata(ctrlRdata), .mdc(mdc), .mdioOut(mdioOut), .mdioOe(mdioOe)
);

// File: tb/tb_mdio_master.sv
module tb_mdio_master;
  localparam logic [4:0] PHY = 5'd1;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ctrlWe = 1'b0;
  logic [7:0]  ctrlWdata = '0;
  logic [7:0]  ctrlRdata;
  logic        divWe = 1'b0;
  logic [7:0]  divWdata = '0;
  logic        txWe = 1'b0;
  logic [15:0] txWdata = '0;
  logic [15:0] rxData;
  logic        mdc, mdioOut, mdioOe;
  logic        mdioIn = 1'b1;

  mdio_master #(.PHY_ADDR(PHY)) dut (
    .clk(clk), .rstN(rstN), .ctrlWe(ctrlWe), .ctrlWdata(ctrlWdata),
    .ctrlRdata(ctrlRdata), .divWe(divWe), .divWdata(divWdata),
    .txWe(txWe), .txWdata(txWdata), .rxData(rxData), .mdc(mdc),
    .mdioOut(mdioOut), .mdioOe(mdioOe), .mdioIn(mdioIn)
  );

  always #4 clk = ~clk;

  int nChecks = 0;
  int nFail = 0;
  int wd = 0;

  // bus monitor / PHY model state
  int          bitIdx = 0;
  int          cyc = 0;
  int          lastRise = 0;
  int          expPeriod = 2;
  bit          periodBad = 0;
  bit          edgeBad = 0;
  logic [63:0] capSeq = '0;
  logic [63:0] capOe = '0;
  logic [15:0] phyData = '0;
  logic        prevMdc = 1'b0;
  logic        prevOut = 1'b1;
  logic        prevBusy = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (mdc && !prevMdc) begin
      if (bitIdx < 64) begin
        capSeq[63-bitIdx] = mdioOut;
        capOe[63-bitIdx]  = mdioOe;
      end
      if (bitIdx > 0 && (cyc - lastRise) != expPeriod) periodBad = 1;
      lastRise = cyc;
      bitIdx++;
    end
    if (!mdc && prevMdc) begin
      if (bitIdx >= 48 && bitIdx < 64) mdioIn = phyData[63-bitIdx];
      else mdioIn = 1'b1;
    end
    if (prevBusy && ctrlRdata[0] && (mdioOut != prevOut) && !(prevMdc && !mdc))
      edgeBad = 1;
    prevMdc  = mdc;
    prevOut  = mdioOut;
    prevBusy = ctrlRdata[0];
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 190000) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog expired actual=%0d expected<190000", wd);
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  end

  function automatic logic [63:0] expFrame(input bit wr, input logic [4:0] ra,
                                           input logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, (wr ? 2'b01 : 2'b10), PHY, ra,
            (wr ? 2'b10 : 2'b11), (wr ? d : 16'hFFFF)};
  endfunction

  task automatic setDiv(input int n);
    @(negedge clk); divWe = 1'b1; divWdata = 8'(n);
    @(negedge clk); divWe = 1'b0;
  endtask

  task automatic runTxn(input bit wr, input logic [4:0] ra, input logic [15:0] d,
                        input int divN, input bit midDiv, input bit midCtrl);
    logic [63:0] mask;
    logic [63:0] ef;
    logic [15:0] prevRx;
    int t;
    string tagF;
    setDiv(divN);
    @(negedge clk); txWe = 1'b1; txWdata = wr ? d : ~d; phyData = d;
    @(negedge clk); txWe = 1'b0;
    bitIdx = 0; periodBad = 0; edgeBad = 0; capSeq = '0; capOe = '0;
    expPeriod = 2 * (divN + 1);
    prevRx = rxData;
    ctrlWe = 1'b1; ctrlWdata = {ra, 1'b0, wr, 1'b1};
    @(negedge clk); ctrlWe = 1'b0;
    t = 1;
    check(ctrlRdata[0] == 1'b1, "R3", "busy after start", 64'(ctrlRdata[0]), 64'd1);
    if (midDiv) begin
      repeat (4) begin @(negedge clk); t++; end
      divWe = 1'b1; divWdata = 8'(divN + 2);
      @(negedge clk); divWe = 1'b0; t++;
    end
    if (midCtrl) begin
      repeat (6) begin @(negedge clk); t++; end
      ctrlWe = 1'b1; ctrlWdata = {~ra, 1'b1, ~wr, 1'b1};
      @(negedge clk); ctrlWe = 1'b0; t++;
    end
    while (ctrlRdata[0] && t < 5000) begin @(negedge clk); t++; end
    t = t - 1;
    check(t == 128 * (divN + 1), "R3", "busy duration", 64'(t), 64'(128 * (divN + 1)));
    mask = wr ? '1 : ~64'h1FFFF;
    ef   = expFrame(wr, ra, d);
    tagF = wr ? "R5" : "R6";
    check((capSeq & mask) == (ef & mask), tagF, "frame bits", capSeq & mask, ef & mask);
    check(capOe == mask, "R6", "output-enable pattern", capOe, mask);
    check(bitIdx == 64, "R4", "mdc rising edges", 64'(bitIdx), 64'd64);
    check(!periodBad, "R4", "mdc period", 64'(periodBad), 64'd0);
    check(!edgeBad, "R8", "mdio change off falling edge", 64'(edgeBad), 64'd0);
    check(!mdc && !mdioOe, "R11", "idle mdc/oe", {62'd0, mdc, mdioOe}, 64'd0);
    if (wr) check(rxData == prevRx, "R7", "rxData kept on write", 64'(rxData), 64'(prevRx));
    else    check(rxData == d, "R7", "read data", 64'(rxData), 64'(d));
    if (midDiv) setDiv(divN);
  endtask

  initial begin
    logic [15:0] dat;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(ctrlRdata == 8'h00, "R1", "ctrlRdata", 64'(ctrlRdata), 64'd0);
    check(rxData == 16'h0, "R1", "rxData", 64'(rxData), 64'd0);
    check({mdc, mdioOe, mdioOut} == 3'b001, "R1", "mdc/oe/out",
          64'({mdc, mdioOe, mdioOut}), 64'd1);
    rstN = 1'b1;
    @(negedge clk);
    check(ctrlRdata == 8'h00, "R1", "ctrlRdata after release", 64'(ctrlRdata), 64'd0);

    // R2 store fields without start
    bitIdx = 0;
    ctrlWe = 1'b1; ctrlWdata = {5'd17, 1'b1, 1'b1, 1'b0};
    @(negedge clk); ctrlWe = 1'b0;
    check(ctrlRdata == {5'd17, 1'b1, 1'b1, 1'b0}, "R2", "field readback",
          64'(ctrlRdata), 64'({5'd17, 1'b1, 1'b1, 1'b0}));
    repeat (20) @(negedge clk);
    check(bitIdx == 0 && !ctrlRdata[0], "R2", "no frame without start",
          64'(bitIdx), 64'd0);

    // R10 sweep of all addresses, write and read, dividers 0..2
    for (int a = 0; a < 32; a++) begin
      dat = 16'hA5C3 ^ 16'(a * 16'h1357);
      runTxn(1'b1, 5'(a), dat, a % 3, 1'b0, 1'b0);
      dat = 16'h3C96 ^ 16'(a * 16'h0B1D);
      runTxn(1'b0, 5'(a), dat, (a + 1) % 3, 1'b0, 1'b0);
    end
    check(1'b1, "R10", "all addresses swept", 64'd32, 64'd32);

    // R4 divider change during frame must not retime it
    runTxn(1'b1, 5'd9, 16'h1234, 1, 1'b1, 1'b0);
    runTxn(1'b0, 5'd22, 16'hBEEF, 3, 1'b0, 1'b0);

    // R9 control write while busy ignored
    runTxn(1'b1, 5'd5, 16'h0F0F, 1, 1'b0, 1'b1);
    check(ctrlRdata == {5'd5, 1'b0, 1'b1, 1'b0}, "R9", "fields after busy write",
          64'(ctrlRdata), 64'({5'd5, 1'b0, 1'b1, 1'b0}));
    repeat (40) @(negedge clk);
    check(bitIdx == 64 && !ctrlRdata[0], "R9", "no extra frame", 64'(bitIdx), 64'd64);
    runTxn(1'b0, 5'd30, 16'h8001, 0, 1'b0, 1'b1);
    check(ctrlRdata == {5'd30, 1'b0, 1'b0, 1'b0}, "R9", "read fields after busy write",
          64'(ctrlRdata), 64'({5'd30, 1'b0, 1'b0, 1'b0}));

    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end
endmodule